// File: doc/BRIEF.md
# Sample-and-Hold Refresh Sequencer

This block paces the refresh of a bank of buffer-amplifier sample-and-hold channels. Every refresh tick it visits the next channel in round-robin order, raises a one-cycle strobe on that channel's line and presents the ten-bit voltage code that the analog stage should capture. The code is the channel's own DAC register value when DAC mode is on. Otherwise it is a fixed preset from an evenly divided reference ladder.

The refresh tick comes from one of two sources. The first is an internal divider that turns the system clock into a nominal 100 kHz rate. The second is an external oscillator pin, which is synchronised and edge-detected. A change of source waits for the tick of the source in use, so a refresh slot is never cut short or doubled. The analog hold stage, the DAC and the ladder are outside this block.

Top module: `hold_refresh_seq`

## Requirements
- R1: While reset is high, and in every cycle after reset until the first tick, `hold_stb` is all zero, `chan_idx` is 0 and `hold_code` is 0.
- R2: Each refresh tick gives exactly one strobe cycle. In that cycle `hold_stb` has only bit `chan_idx` set, and in the next cycle it is zero.
- R3: Strobed channels follow the order 0, 1, ..., NCH-1 and then wrap to 0.
- R4: With the internal source, strobes come every DIV = CLK_HZ/TICK_HZ cycles. The first strobe is seen on the (DIV+1)-th rising clock edge after reset is released.
- R5: With the external source, each rising edge on `ext_osc` gives one strobe, on the fourth rising clock edge after the pin goes high. A falling edge gives none.
- R6: A change of `ext_sel` takes effect only at the next tick of the source in use, and that tick still produces its strobe. Ticks of the other source before that point give no strobe.
- R7: When `dac_mode` is 1 at the tick, `hold_code` equals bits [k*CODE_W +: CODE_W] of `dac_codes`, where k is the strobed channel.
- R8: When `dac_mode` is 0 at the tick, `hold_code` for channel k equals floor((k+1)*(2^CODE_W-1)/(NCH+1)). This is tap k+1 of NCH+1 equal ladder steps.
- R9: Between strobes, `chan_idx` and `hold_code` hold their values even when `dac_mode` or `dac_codes` change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sel | input | 1 | 1 selects the external oscillator, 0 the internal divider |
| ext_osc | input | 1 | Asynchronous external oscillator |
| dac_mode | input | 1 | 1 samples register codes, 0 samples ladder presets |
| dac_codes | input | NCH*CODE_W | Per-channel DAC register codes, channel k at bits [k*CODE_W +: CODE_W] |
| hold_stb | output | NCH | One-hot, one-cycle sample strobe |
| chan_idx | output | $clog2(NCH) | Index of the last strobed channel |
| hold_code | output | CODE_W | Code to sample for the last strobed channel |

## Verification
The internal source is run for more than one full rotation with a distinct register code on each channel. This shows the strobe spacing, the wrap from the last channel to channel 0, and that the register path reaches the right channel. A second rotation with DAC mode off tells the ladder presets apart from the register codes. In that rotation the mode and the codes are also changed between strobes, which must leave the outputs unchanged. The source is then switched while fast external edges arrive, and the next strobe must fall exactly one internal period later. This tells a boundary-aligned switch apart from an immediate one. Last, single external pulses check the synchroniser latency and that falling edges are ignored.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  // Ladder tap k+1 of (nch+1) equal steps across the full code range
  function automatic int unsigned ladder_tap(input int unsigned k, input int unsigned nch,
                                             input int unsigned w);
    return ((k + 1) * ((32'd1 << w) - 1)) / (nch + 1);
  endfunction
endpackage

// File: rtl/hrs_int_osc.sv
module hrs_int_osc #(
  parameter int DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      tick_o <= (cnt == LAST);
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  initial assert (DIV >= 2) else $error("divider must be at least 2");

  // tick leaves the counter freshly restarted
  assert_tick_restart_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (cnt == '0));
  assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/hrs_ext_edge.sv
module hrs_ext_edge (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic tick_o
);
  logic sync1, sync2, last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1  <= 1'b0;
      sync2  <= 1'b0;
      last   <= 1'b0;
      tick_o <= 1'b0;
    end else begin
      sync1  <= pin_i;
      sync2  <= sync1;
      last   <= sync2;
      tick_o <= sync2 & ~last;
    end
  end

  // a rising edge yields a single-cycle pulse
  assert_edge_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/hrs_src_sel.sv
module hrs_src_sel (
  input  logic clk,
  input  logic rst,
  input  logic sel_req,
  input  logic int_tick,
  input  logic ext_tick,
  output logic tick_o
);
  logic use_ext;

  assign tick_o = use_ext ? ext_tick : int_tick;

  always_ff @(posedge clk) begin
    if (rst)         use_ext <= sel_req;
    else if (tick_o) use_ext <= sel_req;
  end

  // source only swaps right after a tick of the old source
  assert_switch_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(use_ext) |-> $past(tick_o));
endmodule

// File: rtl/hold_refresh_seq.sv
module hold_refresh_seq #(
  parameter int NCH     = 12,
  parameter int CODE_W  = 10,
  parameter int CLK_HZ  = 200_000_000,
  parameter int TICK_HZ = 100_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ext_sel,
  input  logic                   ext_osc,
  input  logic                   dac_mode,
  input  logic [NCH*CODE_W-1:0]  dac_codes,
  output logic [NCH-1:0]         hold_stb,
  output logic [$clog2(NCH)-1:0] chan_idx,
  output logic [CODE_W-1:0]      hold_code
);
  localparam int DIV   = CLK_HZ / TICK_HZ;
  localparam int IDX_W = $clog2(NCH);
  localparam logic [IDX_W-1:0] LAST_CH = IDX_W'(NCH - 1);

  logic int_tick, ext_tick, tick;
  logic [IDX_W-1:0]  ch_cnt;
  logic [CODE_W-1:0] reg_tab    [NCH];
  logic [CODE_W-1:0] ladder_tab [NCH];
  logic [CODE_W-1:0] sel_code;

  hrs_int_osc #(.DIV(DIV)) u_int (
    .clk(clk), .rst(rst), .tick_o(int_tick));

  hrs_ext_edge u_ext (
    .clk(clk), .rst(rst), .pin_i(ext_osc), .tick_o(ext_tick));

  hrs_src_sel u_sel (
    .clk(clk), .rst(rst), .sel_req(ext_sel),
    .int_tick(int_tick), .ext_tick(ext_tick), .tick_o(tick));

  for (genvar g = 0; g < NCH; g++) begin : g_tab
    assign reg_tab[g]    = dac_codes[g*CODE_W +: CODE_W];
    assign ladder_tab[g] = CODE_W'(hrs_pkg::ladder_tap(g, NCH, CODE_W));
  end

  assign sel_code = dac_mode ? reg_tab[ch_cnt] : ladder_tab[ch_cnt];

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_cnt    <= '0;
      hold_stb  <= '0;
      chan_idx  <= '0;
      hold_code <= '0;
    end else if (tick) begin
      hold_stb  <= NCH'(1) << ch_cnt;
      chan_idx  <= ch_cnt;
      hold_code <= sel_code;
      ch_cnt    <= (ch_cnt == LAST_CH) ? '0 : ch_cnt + 1'b1;
    end else begin
      hold_stb  <= '0;
    end
  end

  assert_stb_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hold_stb));
  assert_stb_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_stb != '0) |=> (hold_stb == '0));
  assert_stb_matches_idx_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_stb != '0) |-> hold_stb[chan_idx]);
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (rst)
    chan_idx <= LAST_CH);
  assert_hold_idx_R9: assert property (@(posedge clk) disable iff (rst)
    (hold_stb == '0) |-> ($stable(chan_idx) && $stable(hold_code)));
endmodule

// File: tb/sim_hold_refresh_seq.sv
module sim_hold_refresh_seq;
  localparam int NCH = 12, W = 10, CLK_HZ = 2000, TICK_HZ = 100;
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic clk = 1'b0, rst = 1'b1, ext_sel = 1'b0, ext_osc = 1'b0, dac_mode = 1'b1;
  logic [NCH*W-1:0] dac_codes;
  logic [NCH-1:0] hold_stb;
  logic [3:0] chan_idx;
  logic [W-1:0] hold_code;

  int n_chk = 0, n_fail = 0, cyc = 0, exp_ch = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hold_refresh_seq #(.NCH(NCH), .CODE_W(W), .CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
    .clk(clk), .rst(rst), .ext_sel(ext_sel), .ext_osc(ext_osc), .dac_mode(dac_mode),
    .dac_codes(dac_codes), .hold_stb(hold_stb), .chan_idx(chan_idx), .hold_code(hold_code));

  function automatic int reg_val(int k, int salt);
    return (k * 83 + 17 + salt) & 1023;
  endfunction
  function automatic int ladder(int k);
    return ((k + 1) * 1023) / 13;
  endfunction

  task automatic load_codes(int salt);
    for (int k = 0; k < NCH; k++) dac_codes[k*W +: W] = W'(reg_val(k, salt));
  endtask

  task automatic chk(bit ok, string req, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_stb(int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (hold_stb != '0) begin at = cyc; break; end
    end
  endtask

  // check a strobe seen at this negedge, then that it lasts one cycle
  task automatic check_stb(string req, int expc);
    chk(hold_stb == NCH'(1) << exp_ch, "R2 onehot", int'(hold_stb), 1 << exp_ch);
    chk(chan_idx == 4'(exp_ch), "R3 index", int'(chan_idx), exp_ch);
    chk(hold_code == W'(expc), req, int'(hold_code), expc);
    @(negedge clk);
    chk(hold_stb == '0, "R2 one cycle", int'(hold_stb), 0);
    exp_ch = (exp_ch + 1) % NCH;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(hold_stb == '0 && chan_idx == '0 && hold_code == '0, "R1 reset state",
        int'(hold_stb) + int'(chan_idx) + int'(hold_code), 0);
    exp_ch = 0;
  endtask

  task automatic t_internal_dac;
    int r, at, prev;
    ext_sel = 1'b0; dac_mode = 1'b1; load_codes(0);
    t_reset();
    rst = 1'b0; r = cyc;
    repeat (DIV - 2) @(negedge clk);
    chk(hold_stb == '0 && chan_idx == '0, "R1 idle before first tick", int'(hold_stb), 0);
    wait_stb(10, at);
    chk(at - r == DIV + 1, "R4 first strobe", at - r, DIV + 1);
    check_stb("R7 register code", reg_val(0, 0));
    prev = at;
    for (int i = 1; i <= NCH + 1; i++) begin
      wait_stb(DIV + 5, at);
      chk(at - prev == DIV, "R4 spacing", at - prev, DIV);
      prev = at;
      check_stb("R7 register code", reg_val(exp_ch, 0));
    end
  endtask

  task automatic t_preset_hold;
    int at;
    dac_mode = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      wait_stb(DIV + 5, at);
      check_stb("R8 ladder tap", ladder(exp_ch));
      repeat (3) @(negedge clk);
      begin
        logic [3:0] i0; logic [W-1:0] c0;
        i0 = chan_idx; c0 = hold_code;
        dac_mode = 1'b1; load_codes(i + 5);
        repeat (3) @(negedge clk);
        chk(chan_idx == i0 && hold_code == c0, "R9 hold between strobes",
            int'(hold_code), int'(c0));
        dac_mode = 1'b0;
      end
    end
    load_codes(0);
  endtask

  task automatic t_switch;
    int at, ts;
    dac_mode = 1'b1;
    wait_stb(DIV + 5, ts);
    ext_sel = 1'b1;
    check_stb("R7 register code", reg_val(exp_ch, 0));
    for (int p = 0; p < 2; p++) begin
      ext_osc = 1'b1; repeat (2) @(negedge clk);
      ext_osc = 1'b0; repeat (2) @(negedge clk);
    end
    chk(hold_stb == '0, "R6 no early strobe", int'(hold_stb), 0);
    wait_stb(DIV + 5, at);
    chk(at - ts == DIV, "R6 switch at boundary", at - ts, DIV);
    check_stb("R7 register code", reg_val(exp_ch, 0));
  endtask

  task automatic t_external;
    int at, c0;
    repeat (DIV) @(negedge clk);
    chk(hold_stb == '0, "R6 internal ticks ignored", int'(hold_stb), 0);
    for (int j = 0; j < NCH + 2; j++) begin
      ext_osc = 1'b1; c0 = cyc;
      wait_stb(8, at);
      chk(at - c0 == 4, "R5 edge latency", at - c0, 4);
      check_stb("R7 register code", reg_val(exp_ch, 0));
      ext_osc = 1'b0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        chk(hold_stb == '0, "R5 falling edge ignored", int'(hold_stb), 0);
      end
    end
  endtask

  initial begin
    #(5ns * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    load_codes(0);
    t_internal_dac();
    t_preset_hold();
    t_switch();
    t_external();
    t_reset();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule